// File: doc/BRIEF.md
# Serial-Parallel Output Latch Register

This block is an eight-bit input/output shift register with a holding latch behind it. A serial host controls it with an active-low select, a serial clock, a serial data input and a serial data output that can be released. When the select falls, the block captures a parallel input word into the register and puts that word's top bit on the serial output. While the select is low, each rising serial clock edge shifts the register one place toward the MSB and enters the serial input at bit 0. Each falling serial clock edge presents the register's top bit on the serial output. When the select rises, the register is copied into the output latch. The latch drives the eight outputs for as long as the output-enable input is high.

Devices can be chained by feeding each serial output into the next device's serial input, with select and serial clock shared. For n devices the host gives 8n serial clocks under one select pulse. With the serial clock held low, the block works as a parallel-in, parallel-out latch. The block runs on a fast system clock. Select and serial clock pass through synchronizers and edge detectors. Released (high-impedance) pins are modelled as an enable flag next to each data bit.

Top module: `shiftlatch_top`

## Requirements
- R1: One select falling edge loads `par_in` into the register, drives `sdo` to `par_in[7]` and raises `sdo_en`.
- R2: While selected, each serial clock rising edge shifts the register toward bit 7 and takes `sdi` into bit 0. After eight such edges, the first serial bit sits in bit 7 and so controls `drv_out[7]` after the select rises.
- R3: While selected, `sdo` changes only on serial clock falling edges, and it then shows the register's bit 7. The captured word therefore comes out on `sdo` from bit 7 down to bit 0.
- R4: After more than eight serial clocks, `sdo` shows the serial bits that have passed through all eight stages. A second device fed from `sdo` therefore ends up holding the first eight of sixteen bits, and the first device holds the last eight.
- R5: One select rising edge copies the register to `drv_out`. `drv_out` then keeps that value, through any shifting, until the next select rising edge.
- R6: While the select is high, `sdi` and `sck` have no effect, `sdo_en` is 0 and `sdo` reads 0.
- R7: Every bit of `drv_en` equals `oe`. `drv_out` keeps the latched value whatever the level of `oe`.
- R8: With `sck` held low, a select low pulse moves `par_in` to `drv_out`.
- R9: After asynchronous reset, `drv_out` is all zeros and the register is all zeros. `sdo_en` is 0 and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sck |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data input |
| par_in | input | 8 | Parallel word captured on the select falling edge |
| oe | input | 1 | Output enable for drv_out |
| sdo | output | 1 | Serial data output value (0 when released) |
| sdo_en | output | 1 | 1 while sdo is driven |
| drv_out | output | 8 | Latched output data |
| drv_en | output | 8 | Per-bit drive enable of drv_out |

## Verification
The properties assume that select edges and serial clock edges never reach the edge detectors in the same system clock. They also assume that `sdi` and `par_in` stay steady from shortly before a detected edge until the register acts on it, which is three system clocks later. The stimulus spaces every select and serial clock transition six system clocks apart. It sets `sdi` one clock before each serial clock rising edge and holds it until the falling edge. It changes `par_in` only while the select is high. In the chained pair, the downstream input comes from an output that moves only on falling edges, so it is steady at every rising edge.

// File: rtl/shl_pkg.sv
package shl_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic edge_t detect_edge(input logic prev, input logic cur);
    edge_t e;
    e.rise = ~prev & cur;
    e.fall = prev & ~cur;
    return e;
  endfunction

endpackage

// File: rtl/shl_sync_edge.sv
module shl_sync_edge #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           async_in,
  output shl_pkg::edge_t evt
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{INIT}};
      prev  <= INIT;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[TOP];
    end
  end

  assign evt = shl_pkg::detect_edge(prev, chain[TOP]);
endmodule

// File: rtl/shl_io_shift.sv
module shl_io_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         shift_rise,
  input  logic         shift_fall,
  input  logic         sdi,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] io_reg,
  output logic         sdo_q
);
  localparam int MSB = W - 1;

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] r, input logic b);
    return {r[W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_reg <= '0;
      sdo_q  <= 1'b0;
    end else if (capture) begin
      io_reg <= par_in;
      sdo_q  <= par_in[MSB];
    end else begin
      if (shift_rise) io_reg <= shift_in(io_reg, sdi);
      if (shift_fall) sdo_q  <= io_reg[MSB];
    end
  end
endmodule

// File: rtl/shl_out_latch.sv
module shl_out_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         oe,
  output logic [W-1:0] drv_out,
  output logic [W-1:0] drv_en
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= din;
  end

  assign drv_out = held;

  for (genvar i = 0; i < W; i++) begin : g_en
    assign drv_en[i] = oe;
  end
endmodule

// File: rtl/shiftlatch_top.sv
module shiftlatch_top #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sck,
  input  logic         sdi,
  input  logic [W-1:0] par_in,
  input  logic         oe,
  output logic         sdo,
  output logic         sdo_en,
  output logic [W-1:0] drv_out,
  output logic [W-1:0] drv_en
);
  shl_pkg::edge_t cs_evt;
  shl_pkg::edge_t sck_evt;

  // named internal events
  logic         cs_fall;
  logic         cs_rise;
  logic         selected;
  logic         sck_rise_sel;
  logic         sck_fall_sel;
  logic [W-1:0] io_reg;
  logic         sdo_q;

  shl_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) cs_sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(cs_n), .evt(cs_evt)
  );

  shl_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) sck_sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(sck), .evt(sck_evt)
  );

  assign cs_fall = cs_evt.fall;
  assign cs_rise = cs_evt.rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       selected <= 1'b0;
    else if (cs_fall) selected <= 1'b1;
    else if (cs_rise) selected <= 1'b0;
  end

  assign sck_rise_sel = sck_evt.rise & selected;
  assign sck_fall_sel = sck_evt.fall & selected;

  shl_io_shift #(.W(W)) shift_i (
    .clk(clk), .rst_n(rst_n),
    .capture(cs_fall), .shift_rise(sck_rise_sel), .shift_fall(sck_fall_sel),
    .sdi(sdi), .par_in(par_in), .io_reg(io_reg), .sdo_q(sdo_q)
  );

  shl_out_latch #(.W(W)) latch_i (
    .clk(clk), .rst_n(rst_n), .load(cs_rise), .din(io_reg), .oe(oe),
    .drv_out(drv_out), .drv_en(drv_en)
  );

  assign sdo_en = selected;
  assign sdo    = selected & sdo_q;
endmodule

// File: rtl/shiftlatch_checker.sv
module shiftlatch_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_fall,
  input logic         cs_rise,
  input logic         selected,
  input logic         sck_rise_sel,
  input logic         sck_fall_sel,
  input logic         sdi,
  input logic [W-1:0] par_in,
  input logic [W-1:0] io_reg,
  input logic         sdo,
  input logic         sdo_en,
  input logic [W-1:0] drv_out
);
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (io_reg == $past(par_in)) && (sdo == $past(par_in[W-1])) && sdo_en);

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise_sel && !cs_fall) |=> io_reg == {$past(io_reg[W-2:0]), $past(sdi)});

  p_sdo_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !sck_fall_sel && !cs_fall && !cs_rise) |=> $stable(sdo));

  p_latch_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> drv_out == $past(io_reg));

  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(drv_out));

  p_idle_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!selected && !cs_fall) |=> $stable(io_reg) && !sdo_en);
endmodule

bind shiftlatch_top shiftlatch_checker #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .selected(selected), .sck_rise_sel(sck_rise_sel), .sck_fall_sel(sck_fall_sel),
  .sdi(sdi), .par_in(par_in), .io_reg(io_reg), .sdo(sdo), .sdo_en(sdo_en),
  .drv_out(drv_out)
);

// File: tb/shiftlatch_top_tb_top.sv
module shiftlatch_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int SPACE      = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, oe = 1'b0;
  logic [W-1:0] par_a = '0, par_b = '0;
  logic sdo_a, sdo_en_a, sdo_b, sdo_en_b;
  logic [W-1:0] out_a, en_a, out_b, en_b;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // expected model
  logic [W-1:0] ma_reg, mb_reg, ma_lat, mb_lat;
  logic ma_sdo, mb_sdo;

  always #(CLK_PERIOD/2) clk = ~clk;

  shiftlatch_top dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .par_in(par_a),
    .oe(oe), .sdo(sdo_a), .sdo_en(sdo_en_a), .drv_out(out_a), .drv_en(en_a)
  );

  shiftlatch_top dut_b (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdo_a), .par_in(par_b),
    .oe(oe), .sdo(sdo_b), .sdo_en(sdo_en_b), .drv_out(out_b), .drv_en(en_b)
  );

  function automatic logic [W-1:0] m_shift(input logic [W-1:0] r, input logic b);
    logic [W-1:0] n;
    n = r << 1;
    n[0] = b;
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_low(input logic [W-1:0] pa, input logic [W-1:0] pb);
    @(negedge clk);
    par_a = pa; par_b = pb;
    wait_clks(1);
    cs_n = 1'b0;
    wait_clks(SPACE);
    ma_reg = pa; mb_reg = pb; ma_sdo = pa[W-1]; mb_sdo = pb[W-1];
    check("R1 sdo after capture", sdo_a, ma_sdo);
    check("R1 sdo_en after capture", sdo_en_a, 1);
    check("R5 latch held at select fall", out_a, ma_lat);
  endtask

  task automatic sck_bit(input logic b, input int idx);
    logic bin;
    @(negedge clk);
    sdi = b;
    bin = ma_sdo;
    wait_clks(1);
    sck = 1'b1;
    wait_clks(SPACE);
    ma_reg = m_shift(ma_reg, b);
    mb_reg = m_shift(mb_reg, bin);
    check("R3 sdo steady at sck rise", sdo_a, ma_sdo);
    check("R5 latch held while shifting", out_a, ma_lat);
    sck = 1'b0;
    wait_clks(SPACE);
    ma_sdo = ma_reg[W-1];
    mb_sdo = mb_reg[W-1];
    if (idx < W) check("R3 sdo after sck fall", sdo_a, ma_sdo);
    else         check("R4 sdo passes serial bits", sdo_a, ma_sdo);
    check("R4 chained sdo", sdo_b, mb_sdo);
  endtask

  task automatic sel_high();
    @(negedge clk);
    cs_n = 1'b1;
    wait_clks(SPACE);
    ma_lat = ma_reg; mb_lat = mb_reg;
    check("R5 latch loads register", out_a, ma_lat);
    check("R4 chained latch", out_b, mb_lat);
    check("R6 sdo_en released", sdo_en_a, 0);
    check("R6 sdo reads zero", sdo_a, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] p, q, first_word;
    void'($urandom(32'h1b2c3d4e));
    ma_reg = '0; mb_reg = '0; ma_lat = '0; mb_lat = '0; ma_sdo = 1'b0; mb_sdo = 1'b0;
    wait_clks(4);
    // R9 reset state
    check("R9 drv_out zero", out_a, 0);
    check("R9 sdo_en low", sdo_en_a, 0);
    check("R9 sdo zero", sdo_a, 0);
    rst_n = 1'b1;
    wait_clks(4);
    check("R9 after release drv_out", out_a, 0);
    // R9 register cleared: select pulse with no clocks shows it only via capture, so check sdo path later

    // R7 output enable
    oe = 1'b1; wait_clks(1);
    check("R7 drv_en follows oe high", en_a, {W{1'b1}});
    oe = 1'b0; wait_clks(1);
    check("R7 drv_en follows oe low", en_a, 0);
    check("R7 drv_out kept with oe low", out_a, 0);
    oe = 1'b1;

    // R8 parallel mode
    sel_low(8'hA5, 8'h3C);
    sel_high();
    check("R8 parallel word on outputs", out_a, 8'hA5);

    // R1/R3 captured word leaves msb first
    sel_low(8'b1011_0010, 8'h00);
    for (int i = 0; i < W; i++) begin
      sck_bit(1'b0, i);
      if (i < W - 1) check("R3 captured bit order", sdo_a, (8'b1011_0010 >> (W - 2 - i)) & 1);
    end
    sel_high();

    // R2 first serial bit ends in bit 7
    sel_low(8'h00, 8'h00);
    first_word = 8'b1100_1010;
    for (int i = 0; i < W; i++) sck_bit(first_word[W-1-i], i);
    sel_high();
    check("R2 first serial bit on drv_out[7]", out_a[W-1], 1);
    check("R2 serial word on outputs", out_a, first_word);

    // R4 chained sixteen-bit load
    sel_low(8'hFF, 8'hFF);
    p = 8'h9E; q = 8'h41;
    for (int i = 0; i < W; i++) sck_bit(p[W-1-i], i);
    for (int i = 0; i < W; i++) sck_bit(q[W-1-i], W + i);
    sel_high();
    check("R4 downstream holds first byte", out_b, p);
    check("R4 upstream holds second byte", out_a, q);

    // R6 serial lines ignored while select high
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      sdi = k[0];
      sck = 1'b1; wait_clks(SPACE);
      check("R6 sdo_en stays low", sdo_en_a, 0);
      sck = 1'b0; wait_clks(SPACE);
      check("R6 drv_out unchanged", out_a, q);
      check("R6 sdo stays zero", sdo_a, 0);
    end

    // R7 oe low does not disturb latch
    oe = 1'b0; wait_clks(2);
    check("R7 data kept while disabled", out_a, q);
    check("R7 all enables low", en_a, 0);
    oe = 1'b1;

    // random transactions
    for (int t = 0; t < 24; t++) begin
      int nb;
      nb = $urandom_range(0, 4);
      nb = (nb == 0) ? 0 : (nb == 1) ? 3 : (nb == 2) ? 8 : (nb == 3) ? 11 : 16;
      sel_low(W'($urandom), W'($urandom));
      for (int i = 0; i < nb; i++) sck_bit(1'($urandom), i);
      sel_high();
      oe = 1'($urandom);
      wait_clks(1);
      check("R7 enable tracks oe", en_a, {W{oe}});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule